// File: doc/BRIEF.md
# Bus-Master DMA Channel Controller

This block is one DMA channel placed between a storage-bus controller core and a host memory master port. Host software programs a bank of eight 32-bit registers through a single-cycle register port. It loads a byte count, a memory address and a descriptor address into the start registers, then writes a command. The start command copies the start registers into the working registers and enables transfers. Idle disables transfers. Abort cancels the memory request in flight. Flush and descriptor-list mode are accepted and do nothing.

Once transfers are enabled, the core asks for data bursts. Each request carries a direction and a length. The channel clips the length to the remaining working count and checks the direction against the command register. It then issues one memory request at the working address. When memory acknowledges, the working count falls and the working address rises by the amount moved, and the done flag is set when the count reaches zero. The core is told how many bytes were moved, which is zero for a request that was refused or cancelled.

The status word mixes stored flags with the live core interrupt. A mode input selects how the error, abort and done flags are cleared: either by writing ones to them, or as a side effect of reading status.

Top module: `busmaster_dma_ctrl`

## Requirements
- R1: After reset, every register reads zero except three. Working address reads 0xFFFFFFFF, working descriptor address reads 0xFFFFFFFD, and status reads only the live core interrupt in bit 4. Transfers are disabled and no memory request is pending.
- R2: Register indices are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor address, 7 working descriptor address. Writes to 0, 1, 2 and 6 are stored and read back unchanged. Writes to 3, 4 and 7 are ignored.
- R3: A command write whose bits [1:0] are 3 (start) does four things: it copies start count, start address and start descriptor address into their working registers, clears status bits [5:0], and enables transfers.
- R4: A command write with bits [1:0] = 0 (idle) disables transfers. A later burst request then gets a zero-length response and raises no memory request.
- R5: A command write with bits [1:0] = 2 (abort) while a memory request is pending has four effects. It withdraws the request, pulses the core cancel output, answers the core with a zero-length response, and leaves the working count and working address unchanged.
- R6: An accepted burst raises a memory request at the current working address. Its length is the smaller of the requested length and the working count, and its direction matches the request.
- R7: On memory acknowledge, the working count drops by the burst length and the working address rises by it. The core sees a response carrying that length. Status bit 3 (done) is set when the count reaches zero.
- R8: A burst request whose direction differs from command bit 7 (1 = device to memory) is refused: no memory request, zero-length response, counters unchanged.
- R9: A core completion pulse forces the working count to zero and sets done.
- R10: Status bit 4 on read equals the core interrupt input at that moment, and is never stored.
- R11: With the clear mode input high, a status write clears bits 1, 2 and 3 where the written value has ones. Reading status does not clear them.
- R12: With the clear mode input low, reading status returns the flags and then clears bits 1, 2 and 3. A status write has no effect in this mode.
- R13: A command write with bits [1:0] = 1 (flush) changes only the stored command. Transfers stay enabled and the working registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_valid | input | 1 | Register access this cycle |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_index | input | 3 | Register word index |
| hst_wdata | input | 32 | Write data |
| hst_ready | output | 1 | Access accepted (always ready) |
| hst_rdata | output | 32 | Read data for the addressed register, valid in the access cycle |
| stat_wr_clear | input | 1 | 1 = flags cleared by write-one, 0 = cleared by read |
| core_irq | input | 1 | Live interrupt from the controller core |
| core_cmd_done | input | 1 | Core command completion pulse |
| core_cancel | output | 1 | One-cycle pulse telling the core its burst was aborted |
| xfer_enable | output | 1 | Transfers enabled |
| brq_valid | input | 1 | Burst request, held until brq_done |
| brq_to_mem | input | 1 | Request direction, 1 = device to memory |
| brq_len | input | LEN_W (16) | Requested burst length in bytes |
| brq_done | output | 1 | One-cycle burst response |
| brq_moved | output | LEN_W (16) | Bytes moved by the answered burst |
| mem_req | output | 1 | Memory request pending |
| mem_write | output | 1 | 1 = write into memory |
| mem_addr | output | 32 | Memory byte address |
| mem_len | output | LEN_W (16) | Memory transfer length |
| mem_ack | input | 1 | Memory completed the pending request |

## Verification
The hardest situation to reach from the ports is an abort that lands while a memory request is waiting for its acknowledge. The bench holds off the acknowledge and issues the abort command in that window. It then confirms that the counters did not move and that the core receives both a cancel pulse and a zero-length response. A second hard case is a burst whose request exceeds the remaining count, which must end exactly at zero. The bench reaches it by shrinking the count with earlier bursts. Random bursts, register writes and mode changes then drive the working count to zero from varied starting points.

// File: rtl/bmdma_pkg.sv
// Package: shared register indices, command codes and status bit positions
// for the bus-master DMA channel. Assumes 32-bit registers.
package bmdma_pkg;
    localparam int REG_W = 32;
    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        IX_CMD  = 3'd0,
        IX_SCNT = 3'd1,
        IX_SADR = 3'd2,
        IX_WCNT = 3'd3,
        IX_WADR = 3'd4,
        IX_STAT = 3'd5,
        IX_SDSC = 3'd6,
        IX_WDSC = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FLUSH = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        EN_IDLE = 2'd0,
        EN_MEM  = 2'd1,
        EN_RESP = 2'd2
    } eng_state_e;

    localparam int CMD_DIR_BIT = 7;
    localparam int ST_DONE_BIT = 3;
    localparam int ST_IRQ_BIT  = 4;
    localparam logic [REG_W-1:0] ST_STICKY   = 32'h0000_000E;
    localparam logic [REG_W-1:0] ST_STARTCLR = 32'h0000_003F;
    localparam logic [REG_W-1:0] WADR_RST    = 32'hFFFF_FFFF;
    localparam logic [REG_W-1:0] WDSC_RST    = 32'hFFFF_FFFD;
endpackage

// File: rtl/bmdma_regs.sv
// Module: register bank, command decode and status logic of the DMA channel.
// Assumes one host access per cycle. Read data is combinational. The
// clear-on-read side effect takes place on the edge that ends the access.
// Same-cycle update order: engine commit, then core completion, then host
// write. A start write suppresses a done flag raised in the same cycle.
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int DW    = REG_W,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_valid,
    input  logic             hst_write,
    input  logic [IDX_W-1:0] hst_index,
    input  logic [DW-1:0]    hst_wdata,
    output logic [DW-1:0]    hst_rdata,
    input  logic             stat_wr_clear,
    input  logic             core_irq,
    input  logic             core_cmd_done,
    input  logic             commit,
    input  logic [LEN_W-1:0] commit_len,
    output logic [DW-1:0]    wcount,
    output logic [DW-1:0]    waddr,
    output logic             dir_to_mem,
    output logic             xfer_en,
    output logic             abort_now,
    output logic             core_cancel
);
    logic [DW-1:0] cmd_q, scnt_q, sadr_q, wcnt_q, wadr_q, stat_q, sdsc_q, wdsc_q;
    logic [DW-1:0] cmd_n, scnt_n, sadr_n, wcnt_n, wadr_n, stat_n, sdsc_n, wdsc_n;
    logic          en_q, en_n;
    logic          wr, rd, cmd_wr, start_wr, set_done;
    logic [DW-1:0] len_ext;

    assign wr       = hst_valid && hst_write;
    assign rd       = hst_valid && !hst_write;
    assign cmd_wr   = wr && (hst_index == IX_CMD);
    assign start_wr = cmd_wr && (hst_wdata[1:0] == OP_START);
    assign abort_now = cmd_wr && (hst_wdata[1:0] == OP_ABORT);
    assign len_ext  = DW'(commit_len);

    // Read multiplexer; status merges the live core interrupt into bit 4.
    always_comb begin
        case (hst_index)
            IX_CMD:  hst_rdata = cmd_q;
            IX_SCNT: hst_rdata = scnt_q;
            IX_SADR: hst_rdata = sadr_q;
            IX_WCNT: hst_rdata = wcnt_q;
            IX_WADR: hst_rdata = wadr_q;
            IX_STAT: hst_rdata = stat_q | (DW'(core_irq) << ST_IRQ_BIT);
            IX_SDSC: hst_rdata = sdsc_q;
            default: hst_rdata = wdsc_q;
        endcase
    end

    // Next-state computation in the documented priority order.
    always_comb begin
        cmd_n = cmd_q; scnt_n = scnt_q; sadr_n = sadr_q; wcnt_n = wcnt_q;
        wadr_n = wadr_q; stat_n = stat_q; sdsc_n = sdsc_q; wdsc_n = wdsc_q;
        en_n = en_q;
        set_done = 1'b0;
        if (commit) begin
            wcnt_n   = wcnt_q - len_ext;
            wadr_n   = wadr_q + len_ext;
            set_done = (wcnt_q == len_ext);
        end
        if (core_cmd_done) begin
            wcnt_n   = '0;
            set_done = 1'b1;
        end
        if (wr) begin
            case (hst_index)
                IX_CMD: begin
                    cmd_n = hst_wdata;
                    case (hst_wdata[1:0])
                        OP_START: begin
                            wcnt_n = scnt_q;
                            wadr_n = sadr_q;
                            wdsc_n = sdsc_q;
                            stat_n = stat_q & ~ST_STARTCLR;
                            en_n   = 1'b1;
                        end
                        OP_IDLE: en_n = 1'b0;
                        default: ;
                    endcase
                end
                IX_SCNT: scnt_n = hst_wdata;
                IX_SADR: sadr_n = hst_wdata;
                IX_SDSC: sdsc_n = hst_wdata;
                IX_STAT: if (stat_wr_clear) stat_n = stat_q & ~(hst_wdata & ST_STICKY);
                default: ;
            endcase
        end
        if (rd && (hst_index == IX_STAT) && !stat_wr_clear)
            stat_n = stat_q & ~ST_STICKY;
        if (set_done && !start_wr)
            stat_n[ST_DONE_BIT] = 1'b1;
    end

    // Register update with synchronous reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0; scnt_q <= '0; sadr_q <= '0; wcnt_q <= '0;
            wadr_q <= WADR_RST; stat_q <= '0; sdsc_q <= '0; wdsc_q <= WDSC_RST;
            en_q <= 1'b0; core_cancel <= 1'b0;
        end else begin
            cmd_q <= cmd_n; scnt_q <= scnt_n; sadr_q <= sadr_n; wcnt_q <= wcnt_n;
            wadr_q <= wadr_n; stat_q <= stat_n; sdsc_q <= sdsc_n; wdsc_q <= wdsc_n;
            en_q <= en_n; core_cancel <= abort_now;
        end
    end

    assign wcount     = wcnt_q;
    assign waddr      = wadr_q;
    assign dir_to_mem = cmd_q[CMD_DIR_BIT];
    assign xfer_en    = en_q;

    // R3
    start_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (wcnt_q == $past(scnt_q)) && (wadr_q == $past(sadr_q))
                     && (wdsc_q == $past(sdsc_q)) && (stat_q[5:0] == 6'd0) && en_q);
    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wr && !core_cmd_done) |=>
            (wcnt_q == $past(wcnt_q) - DW'($past(commit_len)))
            && (wadr_q == $past(wadr_q) + DW'($past(commit_len))));
    // R9
    core_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_cmd_done && !wr) |=> (wcnt_q == '0) && stat_q[ST_DONE_BIT]);
    // R12
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hst_index == IX_STAT && !stat_wr_clear && !commit && !core_cmd_done)
            |=> (stat_q[3:1] == 3'd0));
    // R10
    irq_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_irq) |-> !stat_q[ST_IRQ_BIT]);
endmodule

// File: rtl/bmdma_engine.sv
// Module: burst engine. It accepts one core burst request at a time, clips
// it to the working count, runs one memory request, and answers with the
// moved length. Assumes the core holds brq_valid until brq_done and drops
// it in the response cycle.
module bmdma_engine
    import bmdma_pkg::*;
#(
    parameter int DW    = REG_W,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brq_valid,
    input  logic             brq_to_mem,
    input  logic [LEN_W-1:0] brq_len,
    output logic             brq_done,
    output logic [LEN_W-1:0] brq_moved,
    input  logic [DW-1:0]    wcount,
    input  logic [DW-1:0]    waddr,
    input  logic             dir_to_mem,
    input  logic             xfer_en,
    input  logic             abort_now,
    output logic             mem_req,
    output logic             mem_write,
    output logic [DW-1:0]    mem_addr,
    output logic [LEN_W-1:0] mem_len,
    input  logic             mem_ack,
    output logic             commit,
    output logic [LEN_W-1:0] commit_len
);
    eng_state_e       state_q;
    logic [LEN_W-1:0] len_q, moved_q, clip;
    logic             dir_q, accept;

    // Clip the requested length to the remaining working count.
    always_comb begin
        if (DW'(brq_len) > wcount) clip = wcount[LEN_W-1:0];
        else                       clip = brq_len;
    end

    assign accept = xfer_en && (brq_to_mem == dir_to_mem) && (clip != '0);

    // Burst sequencing: idle, memory wait, one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EN_IDLE;
            len_q   <= '0;
            moved_q <= '0;
            dir_q   <= 1'b0;
        end else begin
            case (state_q)
                EN_IDLE: if (brq_valid) begin
                    if (accept) begin
                        state_q <= EN_MEM;
                        len_q   <= clip;
                        dir_q   <= brq_to_mem;
                    end else begin
                        state_q <= EN_RESP;
                        moved_q <= '0;
                    end
                end
                EN_MEM: if (abort_now) begin
                    state_q <= EN_RESP;
                    moved_q <= '0;
                end else if (mem_ack) begin
                    state_q <= EN_RESP;
                    moved_q <= len_q;
                end
                default: state_q <= EN_IDLE;
            endcase
        end
    end

    assign mem_req    = (state_q == EN_MEM);
    assign mem_write  = dir_q;
    assign mem_addr   = waddr;
    assign mem_len    = len_q;
    assign commit     = mem_req && mem_ack && !abort_now;
    assign commit_len = len_q;
    assign brq_done   = (state_q == EN_RESP);
    assign brq_moved  = moved_q;

    // R6
    clip_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (DW'(mem_len) <= wcount) && (mem_len != '0));
    // R8
    dir_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EN_IDLE && brq_valid && brq_to_mem != dir_to_mem) |=> !mem_req);
    // R5
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && abort_now) |=> !mem_req && brq_done && (brq_moved == '0));
    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort_now) |=> mem_req && $stable(mem_len));
endmodule

// File: rtl/busmaster_dma_ctrl.sv
// Module: top of the bus-master DMA channel. It joins the register bank and
// the burst engine. Assumes a single clock domain and a host port that is
// always ready.
module busmaster_dma_ctrl
    import bmdma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_valid,
    input  logic             hst_write,
    input  logic [2:0]       hst_index,
    input  logic [31:0]      hst_wdata,
    output logic             hst_ready,
    output logic [31:0]      hst_rdata,
    input  logic             stat_wr_clear,
    input  logic             core_irq,
    input  logic             core_cmd_done,
    output logic             core_cancel,
    output logic             xfer_enable,
    input  logic             brq_valid,
    input  logic             brq_to_mem,
    input  logic [LEN_W-1:0] brq_len,
    output logic             brq_done,
    output logic [LEN_W-1:0] brq_moved,
    output logic             mem_req,
    output logic             mem_write,
    output logic [31:0]      mem_addr,
    output logic [LEN_W-1:0] mem_len,
    input  logic             mem_ack
);
    logic [REG_W-1:0] wcount, waddr;
    logic             dir_to_mem, abort_now, commit;
    logic [LEN_W-1:0] commit_len;

    assign hst_ready = 1'b1;

    bmdma_regs #(.DW(REG_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .hst_valid(hst_valid), .hst_write(hst_write), .hst_index(hst_index),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .stat_wr_clear(stat_wr_clear), .core_irq(core_irq),
        .core_cmd_done(core_cmd_done),
        .commit(commit), .commit_len(commit_len),
        .wcount(wcount), .waddr(waddr), .dir_to_mem(dir_to_mem),
        .xfer_en(xfer_enable), .abort_now(abort_now), .core_cancel(core_cancel)
    );

    bmdma_engine #(.DW(REG_W), .LEN_W(LEN_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .brq_valid(brq_valid), .brq_to_mem(brq_to_mem), .brq_len(brq_len),
        .brq_done(brq_done), .brq_moved(brq_moved),
        .wcount(wcount), .waddr(waddr), .dir_to_mem(dir_to_mem),
        .xfer_en(xfer_enable), .abort_now(abort_now),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_ack(mem_ack),
        .commit(commit), .commit_len(commit_len)
    );
endmodule

// File: tb/busmaster_dma_ctrl_bench.sv
module busmaster_dma_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hst_valid = 0, hst_write = 0;
    logic [2:0] hst_index = 0;
    logic [31:0] hst_wdata = 0;
    logic hst_ready;
    logic [31:0] hst_rdata;
    logic stat_wr_clear = 0, core_irq = 0, core_cmd_done = 0;
    logic core_cancel, xfer_enable;
    logic brq_valid = 0, brq_to_mem = 0;
    logic [LEN_W-1:0] brq_len = 0;
    logic brq_done;
    logic [LEN_W-1:0] brq_moved;
    logic mem_req, mem_write;
    logic [31:0] mem_addr;
    logic [LEN_W-1:0] mem_len;
    logic mem_ack = 0;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [31:0] m_reg [8];
    logic m_en;

    busmaster_dma_ctrl #(.LEN_W(LEN_W)) u_busmaster_dma_ctrl (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int idx);
        if (idx == 5) return m_reg[5] | (32'(core_irq) << 4);
        return m_reg[idx];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = 32'h0;
        m_reg[4] = 32'hFFFF_FFFF;
        m_reg[7] = 32'hFFFF_FFFD;
        m_en = 1'b0;
    endtask

    task automatic hw(input int idx, input logic [31:0] d);
        hst_valid = 1; hst_write = 1; hst_index = 3'(idx); hst_wdata = d;
        @(negedge clk);
        hst_valid = 0; hst_write = 0;
        case (idx)
            0: begin
                m_reg[0] = d;
                if (d[1:0] == 2'd3) begin
                    m_reg[3] = m_reg[1]; m_reg[4] = m_reg[2]; m_reg[7] = m_reg[6];
                    m_reg[5] = m_reg[5] & ~32'h3F; m_en = 1;
                end else if (d[1:0] == 2'd0) m_en = 0;
            end
            1, 2, 6: m_reg[idx] = d;
            5: if (stat_wr_clear) m_reg[5] = m_reg[5] & ~(d & 32'hE);
            default: ;
        endcase
    endtask

    task automatic hr(input string req, input int idx);
        hst_valid = 1; hst_write = 0; hst_index = 3'(idx);
        #1;
        chk(req, hst_rdata, exp_read(idx));
        @(negedge clk);
        hst_valid = 0;
        if (idx == 5 && !stat_wr_clear) m_reg[5] = m_reg[5] & ~32'hE;
    endtask

    task automatic burst(input string rtag, input logic dir, input logic [LEN_W-1:0] len,
                         input int waitc);
        logic [31:0] clip;
        logic acc;
        clip = (32'(len) > m_reg[3]) ? m_reg[3] : 32'(len);
        acc = m_en && (m_reg[0][7] == dir) && (clip != 0);
        brq_valid = 1; brq_to_mem = dir; brq_len = len;
        @(negedge clk);
        if (acc) begin
            chk("R6 mem_req", 32'(mem_req), 1);
            chk("R6 mem_addr", mem_addr, m_reg[4]);
            chk("R6 mem_len", 32'(mem_len), clip);
            chk("R6 mem_write", 32'(mem_write), 32'(dir));
            for (int i = 0; i < waitc; i++) @(negedge clk);
            mem_ack = 1;
            @(negedge clk);
            mem_ack = 0;
            chk("R7 brq_done", 32'(brq_done), 1);
            chk("R7 brq_moved", 32'(brq_moved), clip);
            m_reg[3] = m_reg[3] - clip;
            m_reg[4] = m_reg[4] + clip;
            if (m_reg[3] == 0) m_reg[5][3] = 1'b1;
        end else begin
            chk({rtag, " no mem_req"}, 32'(mem_req), 0);
            chk({rtag, " zero response"}, {31'd0, brq_done} | (32'(brq_moved) << 1), 1);
        end
        brq_valid = 0;
        @(negedge clk);
    endtask

    task automatic core_done_pulse();
        core_cmd_done = 1;
        @(negedge clk);
        core_cmd_done = 0;
        m_reg[3] = 0; m_reg[5][3] = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] sa, wa0, wc0;
        void'($urandom(32'h0005EED5));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 8; i++) hr("R1", i);
        chk("R1 xfer_enable", 32'(xfer_enable), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 hst_ready", 32'(hst_ready), 1);
        // R2 stored and ignored indices
        hw(1, 32'h40); hw(2, 32'h1000); hw(6, 32'h2000);
        hw(3, 32'hDEAD); hw(4, 32'hBEEF); hw(7, 32'hCAFE);
        for (int i = 1; i < 8; i++) if (i != 5) hr("R2", i);
        // R3 start, device to memory
        hw(0, 32'h83);
        chk("R3 xfer_enable", 32'(xfer_enable), 1);
        hr("R3", 3); hr("R3", 4); hr("R3", 7); hr("R3", 5);
        burst("R6", 1, 16'h10, 2);
        burst("R8", 0, 16'h10, 0);
        hr("R8", 3);
        // R6 clip to remaining count, R7 done at zero
        burst("R6", 1, 16'h100, 0);
        hr("R7", 3); hr("R7", 4);
        // R10 and R12: read-clear mode with live interrupt
        core_irq = 1;
        hr("R10", 5);
        chk("R12 done cleared", m_reg[5], 0);
        hr("R12", 5);
        hw(5, 32'h0); core_irq = 0;
        // R11 write-one clear mode
        hw(0, 32'h83);
        stat_wr_clear = 1;
        core_done_pulse();
        hr("R9", 3); hr("R9", 5); hr("R11", 5);
        hw(5, 32'h0); hr("R11", 5);
        hw(5, 32'h8); hr("R11", 5);
        stat_wr_clear = 0;
        // R13 flush keeps enable, R4 idle refuses
        hw(0, 32'h83);
        hw(0, 32'h81);
        chk("R13 xfer_enable", 32'(xfer_enable), 1);
        hr("R13", 0); hr("R13", 3);
        burst("R13", 1, 16'h8, 1);
        hw(0, 32'h80);
        chk("R4 xfer_enable", 32'(xfer_enable), 0);
        burst("R4", 1, 16'h8, 0);
        // R5 abort while memory request pending
        hw(0, 32'h83);
        wc0 = m_reg[3]; wa0 = m_reg[4];
        brq_valid = 1; brq_to_mem = 1; brq_len = 16'h4;
        @(negedge clk);
        chk("R5 mem_req before abort", 32'(mem_req), 1);
        hw(0, 32'h82);
        chk("R5 mem_req dropped", 32'(mem_req), 0);
        chk("R5 core_cancel", 32'(core_cancel), 1);
        chk("R5 brq_done", 32'(brq_done), 1);
        chk("R5 brq_moved", 32'(brq_moved), 0);
        brq_valid = 0;
        @(negedge clk);
        hr("R5", 3); chk("R5 count kept", m_reg[3], wc0);
        hr("R5", 4); chk("R5 addr kept", m_reg[4], wa0);
        // Random phase
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 9);
            core_irq = $urandom_range(0, 1);
            case (op)
                0: begin
                    sa = $urandom;
                    hw(0, {24'd0, 1'($urandom_range(0, 1)), 5'd0, 2'($urandom_range(0, 3))});
                end
                1: hw($urandom_range(1, 7), $urandom_range(0, 255));
                2: hr("R2", $urandom_range(0, 7));
                3: stat_wr_clear = $urandom_range(0, 1);
                4: core_done_pulse();
                5: hw(5, $urandom);
                6: hw(0, {24'd0, m_reg[0][7], 7'd3});
                default: burst("R8", $urandom_range(0, 1), 16'($urandom_range(0, 64)),
                               $urandom_range(0, 2));
            endcase
        end
        for (int i = 0; i < 8; i++) hr("R2", i);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule